// File: doc/BRIEF.md
# Debug Unit Control and Status Register

This block is the 32-bit control and status word of an on-chip debug unit. It follows the state of a breakpoint sequence with one or two levels. It also holds four sticky flags that record why the core stopped: a fault during fault handling, a hardware breakpoint trigger, a halt instruction, or the external breakpoint pin. A read-only revision field and two writable control bits complete the word. The first control bit blocks writes from the processor. The second selects the mode that a trace exception enters.

The word has two access ports. The processor bus port can read it and write it. The external debugger command port can also read it and write it. Each write carries its source, so the block can apply the write-inhibit rule. Event strobes come from the comparators and the core: breakpoint arming, level-1 and level-2 hits, the four halt causes, and the debugger's GO command. The block also receives writes to the trigger definition register, because such a write clears the breakpoint state. A read returns the word as it stood before any clear-on-read. The clears then take effect at the same clock edge that loads the read data.

Top module: `dbg_csr`

## Requirements
- R1: After a synchronous reset, every field is zero. `rd_data`, `wr_inhibit` and `trace_emu` are 0.
- R2: The breakpoint status in bits 31:28 takes only the codes 0000, 0001, 0010, 0101 and 0110.
  - An arm strobe loads 0001.
  - A level-1 hit in 0001 moves to 0101 if the arm selected two levels, and to 0010 otherwise.
  - A level-2 hit in 0101 moves to 0110.
  - A hit in any other state is ignored.
- R3: A write to the trigger definition register clears the breakpoint status to 0000. A processor-sourced trigger write is ignored while write-inhibit is set.
- R4: A read from either port clears the breakpoint status only when it holds 0010 or 0110. A read in any other state leaves it unchanged.
- R5: The fault-on-fault flag (bit 27) is set by its event. It is cleared by any read, and a GO command does not clear it.
- R6: The trigger flag (bit 26), the halt flag (bit 25) and the breakpoint-pin flag (bit 24) are each set by their own event. Each is cleared by a GO command or by any read.
- R7: `rd_data` loads the pre-clear value of the word one clock after a read strobe, and holds that value until the next read.
- R8: When a set event and a clear condition occur in the same cycle, the set wins. This covers a flag event together with a read or GO, an arm or hit together with a trigger write, and a hit together with a read.
- R9: The revision field (bits 23:20) reads 0000. All bits other than 31:24, 16 and 10 read zero, and writes to them have no effect.
- R10: Write-inhibit (bit 16) changes only through debugger writes. While it is set, processor writes have no effect. The output `wr_inhibit` reflects the bit.
- R11: The trace-mode bit (bit 10) is writable by both ports, and the debugger wins when both write in the same cycle. The output `trace_emu` reflects it: 1 selects emulator mode on a trace exception, and 0 selects supervisor mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Processor write strobe to the word |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wdata | input | 32 | Processor write data |
| dbg_wr | input | 1 | Debugger write strobe to the word |
| dbg_rd | input | 1 | Debugger read strobe |
| dbg_wdata | input | 32 | Debugger write data |
| tdr_wr | input | 1 | Write to the trigger definition register |
| tdr_wr_dbg | input | 1 | Source of that write: 1 debugger, 0 processor |
| bkpt_arm | input | 1 | Breakpoints armed |
| bkpt_two_level | input | 1 | With the arm strobe: level 2 enabled |
| l1_hit | input | 1 | Level-1 breakpoint hit |
| l2_hit | input | 1 | Level-2 breakpoint hit |
| ev_fault | input | 1 | Fault-on-fault halt event |
| ev_trg | input | 1 | Hardware trigger halt event |
| ev_halt | input | 1 | Halt instruction event |
| ev_pin | input | 1 | Breakpoint pin event |
| go_cmd | input | 1 | Debugger GO command |
| rd_data | output | 32 | Registered read data |
| wr_inhibit | output | 1 | Processor write inhibit state |
| trace_emu | output | 1 | Trace exception enters emulator mode |

## Verification
The flag logic is checked with a sweep over all 16 combinations of the four halt events.
- Each combination is crossed with three follow-ups: no clear, a read clear, or a GO clear.
- Each case is applied both one cycle after the events and in the same cycle as them.

This separates the read-clear group from the GO-clear group and exposes a lost set on collision. The breakpoint status is checked with every three-hit sequence of level-1 and level-2 hits, under both one-level and two-level arming. Each sequence is read twice, which separates the states that clear on read from those that do not. A walking single-bit write from each port checks the writable mask, the reserved bits and the write-inhibit lockout.

// File: rtl/dbg_csr_pkg.sv
package dbg_csr_pkg;

  localparam int CSR_W     = 32;
  localparam int NUM_FLAGS = 4;

  // breakpoint sequence codes; values are visible in the word
  typedef enum logic [3:0] {
    BS_IDLE  = 4'b0000,
    BS_WAIT1 = 4'b0001,
    BS_HIT1  = 4'b0010,
    BS_WAIT2 = 4'b0101,
    BS_HIT2  = 4'b0110
  } bstat_e;

  // field placement inside the word
  localparam int BSTAT_LSB = 28;
  localparam int FLAG_LSB  = 24;  // pin, halt, trg, fof in bits 24..27
  localparam int REV_LSB   = 20;
  localparam int INH_BIT   = 16;
  localparam int TRC_BIT   = 10;

  // flag indices within the sticky flag vector
  localparam int FL_PIN  = 0;
  localparam int FL_HALT = 1;
  localparam int FL_TRG  = 2;
  localparam int FL_FOF  = 3;

  // flags that the GO command clears (all but fault-on-fault)
  localparam logic [NUM_FLAGS-1:0] GO_CLR_MASK = 4'b0111;

endpackage

// File: rtl/dbg_bstat_fsm.sv
module dbg_bstat_fsm
  import dbg_csr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   arm,
  input  logic   arm_two,
  input  logic   l1_hit,
  input  logic   l2_hit,
  input  logic   tdr_clr,
  input  logic   rd_clr,
  output bstat_e state
);

  bstat_e state_q, state_d;
  logic   two_q, two_d;

  always_comb begin
    state_d = state_q;
    two_d   = two_q;
    if (arm) begin
      state_d = BS_WAIT1;
      two_d   = arm_two;
    end else if (l1_hit && state_q == BS_WAIT1) begin
      state_d = two_q ? BS_WAIT2 : BS_HIT1;
    end else if (l2_hit && state_q == BS_WAIT2) begin
      state_d = BS_HIT2;
    end else if (tdr_clr) begin
      state_d = BS_IDLE;
    end else if (rd_clr && (state_q == BS_HIT1 || state_q == BS_HIT2)) begin
      state_d = BS_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BS_IDLE;
      two_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      two_q   <= two_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/dbg_halt_flags.sv
module dbg_halt_flags #(
  parameter int N = 4,
  parameter logic [N-1:0] GO_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         rd_clr,
  input  logic         go_clr,
  output logic [N-1:0] flags
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic clr;
    if (GO_MASK[i]) begin : g_go
      assign clr = rd_clr | go_clr;
    end else begin : g_rd
      assign clr = rd_clr;
    end

    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr)    flags[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/dbg_ctrl_bits.sv
module dbg_ctrl_bits
  import dbg_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_wr,
  input  logic [CSR_W-1:0] cpu_wdata,
  input  logic             dbg_wr,
  input  logic [CSR_W-1:0] dbg_wdata,
  output logic             inhibit,
  output logic             trace
);

  always_ff @(posedge clk) begin
    if (rst) begin
      inhibit <= 1'b0;
      trace   <= 1'b0;
    end else if (dbg_wr) begin
      inhibit <= dbg_wdata[INH_BIT];
      trace   <= dbg_wdata[TRC_BIT];
    end else if (cpu_wr && !inhibit) begin
      trace   <= cpu_wdata[TRC_BIT];
    end
  end

endmodule

// File: rtl/dbg_csr.sv
module dbg_csr
  import dbg_csr_pkg::*;
#(
  parameter logic [3:0] HW_REV = 4'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cpu_wr,
  input  logic        cpu_rd,
  input  logic [31:0] cpu_wdata,
  input  logic        dbg_wr,
  input  logic        dbg_rd,
  input  logic [31:0] dbg_wdata,
  input  logic        tdr_wr,
  input  logic        tdr_wr_dbg,
  input  logic        bkpt_arm,
  input  logic        bkpt_two_level,
  input  logic        l1_hit,
  input  logic        l2_hit,
  input  logic        ev_fault,
  input  logic        ev_trg,
  input  logic        ev_halt,
  input  logic        ev_pin,
  input  logic        go_cmd,
  output logic [31:0] rd_data,
  output logic        wr_inhibit,
  output logic        trace_emu
);

  logic                 rd_any;
  logic                 tdr_clr;
  logic                 inhibit;
  logic                 trace;
  bstat_e               bstat;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flags;
  logic [CSR_W-1:0]     csr_val;

  assign rd_any  = cpu_rd | dbg_rd;
  assign tdr_clr = tdr_wr & (tdr_wr_dbg | ~inhibit);

  always_comb begin
    flag_set          = '0;
    flag_set[FL_PIN]  = ev_pin;
    flag_set[FL_HALT] = ev_halt;
    flag_set[FL_TRG]  = ev_trg;
    flag_set[FL_FOF]  = ev_fault;
  end

  dbg_bstat_fsm u_bstat (
    .clk     (clk),
    .rst     (rst),
    .arm     (bkpt_arm),
    .arm_two (bkpt_two_level),
    .l1_hit  (l1_hit),
    .l2_hit  (l2_hit),
    .tdr_clr (tdr_clr),
    .rd_clr  (rd_any),
    .state   (bstat)
  );

  dbg_halt_flags #(
    .N       (NUM_FLAGS),
    .GO_MASK (GO_CLR_MASK)
  ) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set    (flag_set),
    .rd_clr (rd_any),
    .go_clr (go_cmd),
    .flags  (flags)
  );

  dbg_ctrl_bits u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .dbg_wr    (dbg_wr),
    .dbg_wdata (dbg_wdata),
    .inhibit   (inhibit),
    .trace     (trace)
  );

  always_comb begin
    csr_val = '0;
    csr_val[BSTAT_LSB +: 4]        = bstat;
    csr_val[FLAG_LSB +: NUM_FLAGS] = flags;
    csr_val[REV_LSB +: 4]          = HW_REV;
    csr_val[INH_BIT]               = inhibit;
    csr_val[TRC_BIT]               = trace;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_any) rd_data <= csr_val;
  end

  assign wr_inhibit = inhibit;
  assign trace_emu  = trace;

endmodule

// File: rtl/dbg_csr_chk.sv
module dbg_csr_chk (
  input logic        clk,
  input logic        rst,
  input logic        cpu_rd,
  input logic        dbg_rd,
  input logic        cpu_wr,
  input logic        dbg_wr,
  input logic        go_cmd,
  input logic        ev_fault,
  input logic        ev_trg,
  input logic        tdr_wr,
  input logic        tdr_wr_dbg,
  input logic        bkpt_arm,
  input logic        l1_hit,
  input logic        l2_hit,
  input logic [31:0] csr_val,
  input logic [31:0] rd_data,
  input logic        wr_inhibit
);

  AST_BSTAT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    csr_val[31:28] inside {4'b0000, 4'b0001, 4'b0010, 4'b0101, 4'b0110}); // R2

  AST_TDR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (tdr_wr && tdr_wr_dbg && !bkpt_arm && !l1_hit && !l2_hit) |=> csr_val[31:28] == 4'b0000); // R3

  AST_FOF_READ_CLR: assert property (@(posedge clk) disable iff (rst)
    ((cpu_rd || dbg_rd) && !ev_fault) |=> !csr_val[27]); // R5

  AST_GO_CLR_TRG: assert property (@(posedge clk) disable iff (rst)
    (go_cmd && !ev_trg) |=> !csr_val[26]); // R6

  AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd || dbg_rd) |=> rd_data == $past(csr_val)); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ev_trg |=> csr_val[26]); // R8

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data & 32'h00FE_FBFF) == 32'h0); // R9

  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_inhibit && cpu_wr && !dbg_wr) |=> $stable(csr_val[16:0])); // R10

endmodule

bind dbg_csr dbg_csr_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_rd     (cpu_rd),
  .dbg_rd     (dbg_rd),
  .cpu_wr     (cpu_wr),
  .dbg_wr     (dbg_wr),
  .go_cmd     (go_cmd),
  .ev_fault   (ev_fault),
  .ev_trg     (ev_trg),
  .tdr_wr     (tdr_wr),
  .tdr_wr_dbg (tdr_wr_dbg),
  .bkpt_arm   (bkpt_arm),
  .l1_hit     (l1_hit),
  .l2_hit     (l2_hit),
  .csr_val    (csr_val),
  .rd_data    (rd_data),
  .wr_inhibit (wr_inhibit)
);

// File: tb/tb_dbg_csr.sv
module tb_dbg_csr;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] WR_MASK = 32'h0001_0400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr = 0, cpu_rd = 0, dbg_wr = 0, dbg_rd = 0;
  logic [31:0] cpu_wdata = '0, dbg_wdata = '0;
  logic        tdr_wr = 0, tdr_wr_dbg = 0;
  logic        bkpt_arm = 0, bkpt_two_level = 0, l1_hit = 0, l2_hit = 0;
  logic        ev_fault = 0, ev_trg = 0, ev_halt = 0, ev_pin = 0, go_cmd = 0;
  logic [31:0] rd_data;
  logic        wr_inhibit, trace_emu;

  int  total = 0;
  int  bad = 0;
  bit  done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_csr dut (
    .clk(clk), .rst(rst),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
    .dbg_wr(dbg_wr), .dbg_rd(dbg_rd), .dbg_wdata(dbg_wdata),
    .tdr_wr(tdr_wr), .tdr_wr_dbg(tdr_wr_dbg),
    .bkpt_arm(bkpt_arm), .bkpt_two_level(bkpt_two_level),
    .l1_hit(l1_hit), .l2_hit(l2_hit),
    .ev_fault(ev_fault), .ev_trg(ev_trg), .ev_halt(ev_halt), .ev_pin(ev_pin),
    .go_cmd(go_cmd),
    .rd_data(rd_data), .wr_inhibit(wr_inhibit), .trace_emu(trace_emu)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(output logic [31:0] v);
    dbg_rd = 1; tick(); dbg_rd = 0;
    v = rd_data;
  endtask

  task automatic dwr(input logic [31:0] d);
    dbg_wr = 1; dbg_wdata = d; tick(); dbg_wr = 0; dbg_wdata = '0;
  endtask

  task automatic cwr(input logic [31:0] d);
    cpu_wr = 1; cpu_wdata = d; tick(); cpu_wr = 0; cpu_wdata = '0;
  endtask

  task automatic tdr(input logic src_dbg);
    tdr_wr = 1; tdr_wr_dbg = src_dbg; tick(); tdr_wr = 0; tdr_wr_dbg = 0;
  endtask

  task automatic arm(input logic two);
    bkpt_arm = 1; bkpt_two_level = two; tick(); bkpt_arm = 0; bkpt_two_level = 0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [3:0]  st;
    logic [3:0]  ef;
    repeat (3) tick();
    rst = 0;
    // R1 reset state
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 outputs", {30'h0, wr_inhibit, trace_emu}, 32'h0);
    rd(v);
    chk("R1 word", v, 32'h0);

    // R5 R6 R8 flag sweep: events x clear kind x timing
    for (int m = 0; m < 16; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int c = 0; c < 3; c++) begin
          rd(v); rd(v);
          {ev_fault, ev_trg, ev_halt, ev_pin} = 4'(m);
          if (s == 0) begin
            tick();
            {ev_fault, ev_trg, ev_halt, ev_pin} = 4'h0;
          end
          cpu_rd = (c == 1);
          go_cmd = (c == 2);
          tick();
          {ev_fault, ev_trg, ev_halt, ev_pin} = 4'h0;
          cpu_rd = 0; go_cmd = 0;
          rd(v);
          if (s == 1)      ef = 4'(m);
          else if (c == 0) ef = 4'(m);
          else if (c == 1) ef = 4'h0;
          else             ef = 4'(m) & 4'b1000;
          chk($sformatf("R5 R6 R8 flags m=%0d s=%0d c=%0d", m, s, c), v, {4'h0, ef, 24'h0});
        end
      end
    end

    // R2 R4 R3 breakpoint sequence sweep
    for (int two = 0; two < 2; two++) begin
      for (int seq = 0; seq < 8; seq++) begin
        tdr(1'b1);
        rd(v);
        arm(1'(two));
        st = 4'b0001;
        for (int k = 0; k < 3; k++) begin
          if (seq[k]) begin
            l2_hit = 1;
            if (st == 4'b0101) st = 4'b0110;
          end else begin
            l1_hit = 1;
            if (st == 4'b0001) st = (two != 0) ? 4'b0101 : 4'b0010;
          end
          tick();
          l1_hit = 0; l2_hit = 0;
        end
        rd(v);
        chk($sformatf("R2 state two=%0d seq=%0d", two, seq), v, {st, 28'h0});
        rd(v);
        chk($sformatf("R4 after read two=%0d seq=%0d", two, seq), v,
            {((st == 4'b0010 || st == 4'b0110) ? 4'h0 : st), 28'h0});
        tdr(1'b1);
        rd(v);
        chk($sformatf("R3 trigger write two=%0d seq=%0d", two, seq), v, 32'h0);
      end
    end

    // R8 arm and trigger write in the same cycle: arm wins
    bkpt_arm = 1; tdr_wr = 1; tdr_wr_dbg = 1; tick();
    bkpt_arm = 0; tdr_wr = 0; tdr_wr_dbg = 0;
    rd(v);
    chk("R8 arm over trigger write", v, 32'h1000_0000);
    // R8 hit and read in the same cycle: hit wins
    l1_hit = 1; cpu_rd = 1; tick(); l1_hit = 0; cpu_rd = 0;
    chk("R7 pre-clear read value", rd_data, 32'h1000_0000);
    rd(v);
    chk("R8 hit over read", v, 32'h2000_0000);
    rd(v);
    chk("R4 hit cleared by read", v, 32'h0);

    // R9 R10 R11 walking-bit writes
    for (int b = 0; b < 32; b++) begin
      dwr(32'h1 << b);
      rd(v);
      chk($sformatf("R9 R11 debugger write bit %0d", b), v, (32'h1 << b) & WR_MASK);
      dwr(32'h0);
      cwr(32'h1 << b);
      rd(v);
      chk($sformatf("R9 R10 processor write bit %0d", b), v, (b == 10) ? 32'h400 : 32'h0);
      cwr(32'h0);
    end

    // R10 inhibit lockout
    dwr(32'h0001_0000);
    chk("R10 wr_inhibit out", {31'h0, wr_inhibit}, 32'h1);
    cwr(32'h0000_0400);
    cwr(32'h0);
    rd(v);
    chk("R10 processor write ignored", v, 32'h0001_0000);
    chk("R11 trace_emu held", {31'h0, trace_emu}, 32'h0);
    arm(1'b0);
    tdr(1'b0);
    rd(v);
    chk("R3 inhibited processor trigger write", v, 32'h1001_0000);
    tdr(1'b1);
    // R11 debugger beats processor in the same cycle
    dbg_wr = 1; dbg_wdata = 32'h400; cpu_wr = 1; cpu_wdata = 32'h0; tick();
    dbg_wr = 0; cpu_wr = 0; dbg_wdata = '0;
    chk("R11 trace_emu set", {31'h0, trace_emu}, 32'h1);
    chk("R10 inhibit released", {31'h0, wr_inhibit}, 32'h0);
    rd(v);
    chk("R11 word after write", v, 32'h0000_0400);

    done = 1;
    summary();
    $finish;
  end

endmodule